// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor with four instructions (load, store, add, jump). It produces the datapath control word. The control word comes from a fixed control store of micro-words. A 5-bit micro-address register selects the current micro-word. Every micro-word holds a set of datapath strobes, two candidate successor addresses and a set of condition flags. The first successor is taken when the step runs straight on. The second is taken when the step branches. The flags are one end-of-routine flag and four opcode-match flags. On every clock edge the register loads one of the two successors. A branch is taken when the end-of-routine flag is set, or when an opcode-match flag is set and the instruction decoded from the two opcode bits is the same instruction.

Each instruction is chosen by a chain of four test steps, one instruction per step, and not by a mapping table. Because of this, the sequencing logic never decodes the micro-address itself. The routines could be placed anywhere in the control store without any change to that logic. The states are the micro-addresses, each with its own name:

- Fetch routine: `UA_FT_ADDR` (1), `UA_FT_READ` (2), `UA_FT_LOAD` (3).
- Load routine: `UA_LD_ADDR` (4), `UA_LD_READ` (5), `UA_LD_MOVE` (6).
- Opcode tests: `UA_DS_LOAD` (7), `UA_DS_STORE` (8), `UA_DS_ADD` (9), `UA_DS_JUMP` (10).
- Store routine: `UA_ST_ADDR` (11), `UA_ST_WRITE` (12).
- Add routine: `UA_AD_ADDR` (13), `UA_AD_READ` (14), `UA_AD_SUM` (15), `UA_AD_BACK` (16).
- Jump routine: `UA_JP_TAKE` (17).
- Unused word: `UA_VOID` (0).

The transitions are:

- Straight on: 1→2, 2→3, 4→5, 5→6, 11→12, 13→14, 14→15, 15→16.
- End of fetch: 3→7.
- End of each routine: 6→1, 12→1, 16→1, 17→1.
- Opcode tests: 7→4 on load, else 7→8. Then 8→11 on store, else 8→9. Then 9→13 on add, else 9→10. Then 10→17 on jump, else 10→7.

Top module: `microcode_sequencer`

## Requirements
- R1: While reset is asserted (active-low, asynchronous) and on the first edge after it is released, `uaddr` is 1 and `ctrl_bus` is 0x00001, which is bit 0 only.
- R2: Steps without a condition go straight on: 1→2→3, 4→5→6, 11→12 and 13→14→15→16, whatever the opcode.
- R3: Opcode bits decode as 00 load, 11 store, 01 add, 10 jump. Word 7 goes to 4 on load, else to 8. Word 8 goes to 11 on store, else to 9. Word 9 goes to 13 on add, else to 10. Word 10 goes to 17 on jump, else back to 7.
- R4: Only words 7 to 10 carry opcode-match flags, and each of them carries exactly one.
- R5: Word 3, the end of fetch, always goes to 7.
- R6: Words 6, 12, 16 and 17, the ends of the routines, always go to 1.
- R7: The fetch words drive these `ctrl_bus` bits. Word 1 drives bit 0 (PC to MAR). Word 2 drives bits 1 to 6 (memory enable, memory read, MBR load from memory, PC as ALU operand, ALU add, carry-in). Word 3 drives bits 7 and 8 (ALU result to PC, MBR to IR).
- R8: The routine words drive these bits:
  - 4 and 13: bit 9 (IR address to MAR).
  - 5 and 14: bits 1, 2 and 3.
  - 6: bit 10 (MBR to AC).
  - 11: bits 9 and 11 (AC to MBR).
  - 12: bits 1, 12 and 13 (memory write, MBR to memory).
  - 15: bits 5, 14 and 15 (MBR and AC as ALU operands).
  - 16: bit 16 (ALU result to AC).
  - 17: bit 17 (IR address to PC).
  - 7 to 10: no bits.
- R9: The opcode affects only the successor chosen in words 7 to 10. Outside those words, changing the opcode changes neither the address trace nor `ctrl_bus`.
- R10: Address 0 is never entered after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the micro-address register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to micro-address 1 |
| opcode | input | 2 | The two opcode bits of the instruction register |
| ctrl_bus | output | 18 | Datapath strobes of the current micro-word |
| uaddr | output | 5 | Current micro-address |

## Verification
The hardest path to reach is the loop from word 10 back to word 7. With a steady opcode it is never taken, because one of the four tests always matches first. To reach it, the bench changes the opcode in the middle of the test chain. It presents add at word 7 and then load at words 8, 9 and 10, so the chain wraps round and then takes the load branch. A second run wraps round with jump and then settles on store. Around these runs the bench changes the opcode during fetch and during the routines to show that it has no effect there. It also asserts reset in the middle of a routine.

// File: rtl/uc_pkg.sv
package uc_pkg;

    localparam int UA_W    = 5;
    localparam int CTRL_W  = 18;
    localparam int OP_W    = 2;
    localparam int NUM_INS = 4;

    typedef enum logic [UA_W-1:0] {
        UA_VOID     = 5'd0,
        UA_FT_ADDR  = 5'd1,
        UA_FT_READ  = 5'd2,
        UA_FT_LOAD  = 5'd3,
        UA_LD_ADDR  = 5'd4,
        UA_LD_READ  = 5'd5,
        UA_LD_MOVE  = 5'd6,
        UA_DS_LOAD  = 5'd7,
        UA_DS_STORE = 5'd8,
        UA_DS_ADD   = 5'd9,
        UA_DS_JUMP  = 5'd10,
        UA_ST_ADDR  = 5'd11,
        UA_ST_WRITE = 5'd12,
        UA_AD_ADDR  = 5'd13,
        UA_AD_READ  = 5'd14,
        UA_AD_SUM   = 5'd15,
        UA_AD_BACK  = 5'd16,
        UA_JP_TAKE  = 5'd17
    } uaddr_e;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_JUMP  = 2'b10,
        OP_STORE = 2'b11
    } opcode_e;

    // one-hot instruction lanes, shared by decoder and match flags
    localparam int INS_LD = 0;
    localparam int INS_ST = 1;
    localparam int INS_AD = 2;
    localparam int INS_JP = 3;

    // control bus bit positions
    localparam int CB_PC_MAR   = 0;
    localparam int CB_MEM_EN   = 1;
    localparam int CB_MEM_RD   = 2;
    localparam int CB_MBR_LD   = 3;
    localparam int CB_PC_ALU   = 4;
    localparam int CB_ALU_ADD  = 5;
    localparam int CB_CARRY    = 6;
    localparam int CB_ALU_PC   = 7;
    localparam int CB_MBR_IR   = 8;
    localparam int CB_IR_MAR   = 9;
    localparam int CB_MBR_AC   = 10;
    localparam int CB_AC_MBR   = 11;
    localparam int CB_MEM_WR   = 12;
    localparam int CB_MBR_MEM  = 13;
    localparam int CB_MBR_ALU  = 14;
    localparam int CB_AC_ALU   = 15;
    localparam int CB_ALU_AC   = 16;
    localparam int CB_IR_PC    = 17;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        uaddr_e             seq_nxt;
        uaddr_e             jmp_nxt;
        logic               last;
        logic [NUM_INS-1:0] match;
    } uword_t;

    function automatic opcode_e ins_code(input int idx);
        case (idx)
            INS_LD:  return OP_LOAD;
            INS_ST:  return OP_STORE;
            INS_AD:  return OP_ADD;
            default: return OP_JUMP;
        endcase
    endfunction

endpackage

// File: rtl/uc_opdec.sv
module uc_opdec
    import uc_pkg::*;
#(
    parameter int OPW  = OP_W,
    parameter int NINS = NUM_INS
) (
    input  logic [OPW-1:0]  opcode,
    output logic [NINS-1:0] ins_hot
);

    for (genvar i = 0; i < NINS; i++) begin : g_lane
        assign ins_hot[i] = (opcode == OPW'(ins_code(i)));
    end

endmodule

// File: rtl/uc_store.sv
module uc_store
    import uc_pkg::*;
(
    input  uaddr_e addr,
    output uword_t word
);

    always_comb begin
        word = '0;
        unique case (addr)
            UA_FT_ADDR: begin
                word.ctrl[CB_PC_MAR] = 1'b1;
                word.seq_nxt         = UA_FT_READ;
            end
            UA_FT_READ: begin
                word.ctrl[CB_MEM_EN]  = 1'b1;
                word.ctrl[CB_MEM_RD]  = 1'b1;
                word.ctrl[CB_MBR_LD]  = 1'b1;
                word.ctrl[CB_PC_ALU]  = 1'b1;
                word.ctrl[CB_ALU_ADD] = 1'b1;
                word.ctrl[CB_CARRY]   = 1'b1;
                word.seq_nxt          = UA_FT_LOAD;
            end
            UA_FT_LOAD: begin
                word.ctrl[CB_ALU_PC] = 1'b1;
                word.ctrl[CB_MBR_IR] = 1'b1;
                word.last            = 1'b1;
                word.jmp_nxt         = UA_DS_LOAD;
            end
            UA_LD_ADDR: begin
                word.ctrl[CB_IR_MAR] = 1'b1;
                word.seq_nxt         = UA_LD_READ;
            end
            UA_LD_READ: begin
                word.ctrl[CB_MEM_EN] = 1'b1;
                word.ctrl[CB_MEM_RD] = 1'b1;
                word.ctrl[CB_MBR_LD] = 1'b1;
                word.seq_nxt         = UA_LD_MOVE;
            end
            UA_LD_MOVE: begin
                word.ctrl[CB_MBR_AC] = 1'b1;
                word.last            = 1'b1;
                word.jmp_nxt         = UA_FT_ADDR;
            end
            UA_DS_LOAD: begin
                word.match[INS_LD] = 1'b1;
                word.seq_nxt       = UA_DS_STORE;
                word.jmp_nxt       = UA_LD_ADDR;
            end
            UA_DS_STORE: begin
                word.match[INS_ST] = 1'b1;
                word.seq_nxt       = UA_DS_ADD;
                word.jmp_nxt       = UA_ST_ADDR;
            end
            UA_DS_ADD: begin
                word.match[INS_AD] = 1'b1;
                word.seq_nxt       = UA_DS_JUMP;
                word.jmp_nxt       = UA_AD_ADDR;
            end
            UA_DS_JUMP: begin
                word.match[INS_JP] = 1'b1;
                word.seq_nxt       = UA_DS_LOAD;
                word.jmp_nxt       = UA_JP_TAKE;
            end
            UA_ST_ADDR: begin
                word.ctrl[CB_IR_MAR] = 1'b1;
                word.ctrl[CB_AC_MBR] = 1'b1;
                word.seq_nxt         = UA_ST_WRITE;
            end
            UA_ST_WRITE: begin
                word.ctrl[CB_MEM_EN]  = 1'b1;
                word.ctrl[CB_MEM_WR]  = 1'b1;
                word.ctrl[CB_MBR_MEM] = 1'b1;
                word.last             = 1'b1;
                word.jmp_nxt          = UA_FT_ADDR;
            end
            UA_AD_ADDR: begin
                word.ctrl[CB_IR_MAR] = 1'b1;
                word.seq_nxt         = UA_AD_READ;
            end
            UA_AD_READ: begin
                word.ctrl[CB_MEM_EN] = 1'b1;
                word.ctrl[CB_MEM_RD] = 1'b1;
                word.ctrl[CB_MBR_LD] = 1'b1;
                word.seq_nxt         = UA_AD_SUM;
            end
            UA_AD_SUM: begin
                word.ctrl[CB_MBR_ALU] = 1'b1;
                word.ctrl[CB_AC_ALU]  = 1'b1;
                word.ctrl[CB_ALU_ADD] = 1'b1;
                word.seq_nxt          = UA_AD_BACK;
            end
            UA_AD_BACK: begin
                word.ctrl[CB_ALU_AC] = 1'b1;
                word.last            = 1'b1;
                word.jmp_nxt         = UA_FT_ADDR;
            end
            UA_JP_TAKE: begin
                word.ctrl[CB_IR_PC] = 1'b1;
                word.last           = 1'b1;
                word.jmp_nxt        = UA_FT_ADDR;
            end
            default: begin
                word = '0;
            end
        endcase
    end

endmodule

// File: rtl/uc_nextsel.sv
module uc_nextsel
    import uc_pkg::*;
#(
    parameter int NINS = NUM_INS
) (
    input  uword_t          word,
    input  logic [NINS-1:0] ins_hot,
    output uaddr_e          nxt
);

    logic branch;

    always_comb begin
        branch = word.last | (|(word.match & ins_hot));
        nxt    = branch ? word.jmp_nxt : word.seq_nxt;
    end

endmodule

// File: rtl/microcode_sequencer.sv
module microcode_sequencer
    import uc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    output logic [CTRL_W-1:0] ctrl_bus,
    output logic [UA_W-1:0]   uaddr
);

    uaddr_e              cur;
    uaddr_e              nxt;
    uword_t              word;
    logic [NUM_INS-1:0]  ins_hot;

    uc_opdec u_dec (
        .opcode  (opcode),
        .ins_hot (ins_hot)
    );

    uc_store u_rom (
        .addr (cur),
        .word (word)
    );

    uc_nextsel u_sel (
        .word    (word),
        .ins_hot (ins_hot),
        .nxt     (nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= UA_FT_ADDR;
        end else begin
            cur <= nxt;
        end
    end

    // outputs
    always_comb begin
        ctrl_bus = word.ctrl;
        uaddr    = cur;
    end

    // R1: first edge after reset release still sees the fetch entry
    a_r1_reset_entry: assert property (@(posedge clk)
        $rose(rst_n) |-> (uaddr == 5'd1));

    // R3: load test word branches on a load opcode, else falls through
    a_r3_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 5'd7 && opcode == 2'b00) |=> (uaddr == 5'd4));
    a_r3_load_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 5'd7 && opcode != 2'b00) |=> (uaddr == 5'd8));

    // R4: match flags only in the test words, at most one at a time
    a_r4_match_place: assert property (@(posedge clk) disable iff (!rst_n)
        (word.match != '0) |-> (uaddr >= 5'd7 && uaddr <= 5'd10 && $onehot0(word.match)));

    // R5: end of fetch enters the opcode tests
    a_r5_fetch_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 5'd3) |=> (uaddr == 5'd7));

    // R6: end of each routine returns to fetch
    a_r6_routine_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 5'd6 || uaddr == 5'd12 || uaddr == 5'd16 || uaddr == 5'd17)
        |=> (uaddr == 5'd1));

    // R10: the unused word is never entered
    a_r10_no_void: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr != 5'd0);

endmodule

// File: tb/microcode_sequencer_bench.sv
`timescale 1ns/1ps
module microcode_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [17:0] ctrl_bus;
    logic [4:0]  uaddr;

    int total = 0;
    int bad = 0;
    int exp_a = 1;
    bit live = 1'b0;
    int tr[$];
    int ops[$];

    localparam logic [1:0] LD = 2'b00, AD = 2'b01, JP = 2'b10, ST = 2'b11;

    always #2.5 clk = ~clk;

    microcode_sequencer u_microcode_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .ctrl_bus (ctrl_bus),
        .uaddr    (uaddr)
    );

    function automatic int ref_next(input int a, input logic [1:0] op);
        case (a)
            1: return 2;
            2: return 3;
            3: return 7;
            4: return 5;
            5: return 6;
            7: return (op == LD) ? 4 : 8;
            8: return (op == ST) ? 11 : 9;
            9: return (op == AD) ? 13 : 10;
            10: return (op == JP) ? 17 : 7;
            11: return 12;
            13: return 14;
            14: return 15;
            15: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic logic [17:0] ref_ctrl(input int a);
        logic [17:0] v;
        v = '0;
        case (a)
            1: v[0] = 1'b1;
            2: v[6:1] = 6'h3f;
            3: begin v[7] = 1'b1; v[8] = 1'b1; end
            4, 13: v[9] = 1'b1;
            5, 14: v[3:1] = 3'h7;
            6: v[10] = 1'b1;
            11: begin v[9] = 1'b1; v[11] = 1'b1; end
            12: begin v[1] = 1'b1; v[12] = 1'b1; v[13] = 1'b1; end
            15: begin v[5] = 1'b1; v[14] = 1'b1; v[15] = 1'b1; end
            16: v[16] = 1'b1;
            17: v[17] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string addr_req(input int a);
        if (a == 3) return "R5";
        if (a >= 7 && a <= 10) return "R3";
        if (a == 6 || a == 12 || a == 16 || a == 17) return "R6";
        return "R2";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_a <= 1;
        else        exp_a <= ref_next(exp_a, opcode);
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live) begin
            check(uaddr == 5'(exp_a), addr_req(exp_a), uaddr, exp_a);
            check(ctrl_bus == ref_ctrl(exp_a),
                  (exp_a <= 3) ? "R7" : "R8", ctrl_bus, ref_ctrl(exp_a));
            check(uaddr != 5'd0, "R10", uaddr, 1);
        end
    end

    // walks tr[] step by step, driving ops[i] while at tr[i]
    task automatic run_trace(input string req);
        for (int i = 0; i < tr.size(); i++) begin
            check(uaddr == 5'(tr[i]), req, uaddr, tr[i]);
            opcode = ops[i];
            if (i < tr.size() - 1) @(negedge clk);
        end
    endtask

    task automatic fill_ops(input logic [1:0] op);
        ops = {};
        for (int i = 0; i < tr.size(); i++) ops.push_back(op);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check(uaddr == 5'd1, "R1", uaddr, 1);
        check(ctrl_bus == 18'h00001, "R1", ctrl_bus, 18'h00001);
        @(negedge clk);
        check(uaddr == 5'd1, "R1", uaddr, 1);
        rst_n = 1'b1;
        live = 1'b1;

        // R3 R6: each opcode with a steady value
        tr = '{1, 2, 3, 7, 8, 9, 13, 14, 15, 16, 1};
        fill_ops(AD);
        run_trace("R3 add");
        tr = '{1, 2, 3, 7, 4, 5, 6, 1};
        fill_ops(LD);
        run_trace("R3 load");
        tr = '{1, 2, 3, 7, 8, 11, 12, 1};
        fill_ops(ST);
        run_trace("R3 store");
        tr = '{1, 2, 3, 7, 8, 9, 10, 17, 1};
        fill_ops(JP);
        run_trace("R3 jump");

        // R9: opcode changes outside the tests; R3: chain wraps 10 -> 7
        tr  = '{1, 2, 3, 7, 8, 9, 10, 7, 4, 5, 6, 1};
        ops = '{JP, ST, AD, AD, LD, LD, LD, LD, ST, AD, JP, LD};
        run_trace("R9 wrap to load");
        tr  = '{1, 2, 3, 7, 8, 9, 10, 7, 8, 11, 12, 1};
        ops = '{LD, AD, JP, JP, JP, JP, ST, ST, ST, LD, AD, AD};
        run_trace("R9 wrap to store");
        tr  = '{1, 2, 3, 7, 8, 9, 13, 14, 15, 16, 1};
        ops = '{LD, JP, ST, AD, AD, AD, LD, ST, JP, LD, AD};
        run_trace("R9 add with noise");

        // R1: reset in the middle of the add routine
        tr = '{1, 2, 3, 7, 8, 9, 13, 14};
        fill_ops(AD);
        run_trace("R2 add prefix");
        #1 rst_n = 1'b0;
        #0.5;
        check(uaddr == 5'd1, "R1 mid reset", uaddr, 1);
        check(ctrl_bus == 18'h00001, "R1 mid reset", ctrl_bus, 18'h00001);
        @(negedge clk);
        rst_n = 1'b1;
        tr = '{1, 2, 3, 7, 8, 9, 10, 17, 1};
        fill_ops(JP);
        run_trace("R1 restart jump");

        @(negedge clk);
        live = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule